// File: doc/BRIEF.md
# Bus Arbitration Controller

This block decides, cycle by cycle, whether the local processor owns a shared external bus. It has four states: reset, implicit owner, explicit owner and external owner. In the implicit-owner state the grant is held but the core has no transfer to run, so the address and control lines stay three-stated. In the explicit-owner state the block drives the bus and raises its bus-driven output. In the external-owner state another master has the bus. Every transition takes place on the rising clock edge.

A watchdog reset has the same effect as the system reset. Either one pulls the block back to the reset state from any other state. The block can use two wires or three. In two-wire mode a single partner needs only the grant and the bus-driven line, and the request output is held low. In three-wire mode the request output goes to an external arbiter. The mode input is captured only while the block is in reset. If the grant is withdrawn while the block owns the bus, the block gives up the bus only at the end of the current transfer, which the bus-cycle engine marks with `cyc_end`.

Top module: `busarb_ctrl`

## Requirements
- R1: With `rst_n` low at a rising edge, the block enters the reset state from any state, and `bus_req`, `bus_driven` and `addr_oe` are all low.
- R2: With `wdog_rst` high at a rising edge, the block enters the reset state from any state, with the same outputs as in R1.
- R3: From the reset state, with both resets inactive, the next state is implicit owner if `bus_grant` is high and external owner if it is low.
- R4: In the implicit-owner state `bus_driven` and `addr_oe` are low. If `bus_grant` is low at an edge, the block moves to external owner.
- R5: From implicit owner, with `bus_grant` and `core_req` both high at an edge, the block enters explicit owner, and `bus_driven` and `addr_oe` go high after that edge.
- R6: In explicit owner the state holds while `cyc_end` is low. At an edge with `cyc_end` high, the block moves to external owner if `bus_grant` is low, moves to implicit owner if `bus_grant` is high and `core_req` is low, and otherwise stays in explicit owner.
- R7: From external owner, with `bus_grant` high at an edge, the block moves to implicit owner.
- R8: `bus_req` is high exactly when three-wire mode is latched, `core_req` is high, `bus_grant` is low and the block is not in the reset state.
- R9: With two-wire mode latched (`three_wire` = 0), `bus_req` stays low whatever the other inputs do.
- R10: `three_wire` is captured at edges where the block is in the reset state or a reset is active. Changes at any other edge have no effect on `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous system reset, active low |
| wdog_rst | input | 1 | Synchronous watchdog reset, active high |
| three_wire | input | 1 | Mode select: 1 = three-wire with an external arbiter, 0 = two-wire |
| bus_grant | input | 1 | Bus grant from the partner or the arbiter, active high |
| core_req | input | 1 | The core has a transfer pending |
| cyc_end | input | 1 | Last clock of the current bus transfer, from the bus-cycle engine |
| bus_req | output | 1 | Bus request toward the external arbiter |
| bus_driven | output | 1 | The block is actively driving the bus |
| addr_oe | output | 1 | Output enable for the address and control lines; low means three-stated |

## Verification
The bench builds two copies side by side and drives the same inputs into both. One copy uses the default `ONEHOT_STATE = 0`, which stores the state in binary. The other uses `ONEHOT_STATE = 1`, which stores the state one-hot. Every check compares both copies with the expected value, so both state-storage variants are covered for every transition, including the long transfer held across a lost grant and the watchdog abort in the middle of a transfer.

// File: rtl/busarb_pkg.sv
// Package: shared state type for the bus arbitration controller.
// Assumes four states; the encoding values double as one-hot bit indices.
package busarb_pkg;

    typedef enum logic [1:0] {
        ARB_RESET    = 2'd0,
        ARB_IMPLICIT = 2'd1,
        ARB_EXPLICIT = 2'd2,
        ARB_EXTERNAL = 2'd3
    } arb_state_e;

    localparam int ARB_NSTATES = 4;
    localparam int ARB_SW      = $clog2(ARB_NSTATES);

    // Turns a state value into its one-hot vector.
    function automatic logic [ARB_NSTATES-1:0] arb_onehot(arb_state_e s);
        logic [ARB_NSTATES-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/busarb_next.sv
// Module: next-state logic of the arbitration FSM.
// Assumes all inputs are synchronous to clk; a reset request overrides everything.
module busarb_next
    import busarb_pkg::*;
(
    input  arb_state_e st,
    input  logic       rst_n,
    input  logic       wdog_rst,
    input  logic       bus_grant,
    input  logic       core_req,
    input  logic       cyc_end,
    output arb_state_e nxt
);

    // Picks the state for the next rising edge.
    always_comb begin
        nxt = st;
        if (!rst_n || wdog_rst) begin
            nxt = ARB_RESET;
        end else begin
            unique case (st)
                ARB_RESET:    nxt = bus_grant ? ARB_IMPLICIT : ARB_EXTERNAL;
                ARB_IMPLICIT: begin
                    if (!bus_grant)     nxt = ARB_EXTERNAL;
                    else if (core_req)  nxt = ARB_EXPLICIT;
                end
                ARB_EXPLICIT: begin
                    if (cyc_end) begin
                        if (!bus_grant)     nxt = ARB_EXTERNAL;
                        else if (!core_req) nxt = ARB_IMPLICIT;
                    end
                end
                ARB_EXTERNAL: begin
                    if (bus_grant) nxt = ARB_IMPLICIT;
                end
                default:      nxt = ARB_RESET;
            endcase
        end
    end

endmodule

// File: rtl/busarb_state_reg.sv
// Module: state storage, binary or one-hot depending on ONEHOT_STATE.
// Assumes nxt already folds in both resets; rst_n is also honoured here.
module busarb_state_reg
    import busarb_pkg::*;
#(
    parameter bit ONEHOT_STATE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  arb_state_e nxt,
    output arb_state_e st
);

    generate
        if (ONEHOT_STATE) begin : g_onehot
            logic [ARB_NSTATES-1:0] oh_q;

            // Holds the one-hot state vector.
            always_ff @(posedge clk) begin
                if (!rst_n) oh_q <= arb_onehot(ARB_RESET);
                else        oh_q <= arb_onehot(nxt);
            end

            // Decodes the one-hot vector back into the state type.
            always_comb begin
                st = ARB_RESET;
                for (int i = 0; i < ARB_NSTATES; i++) begin
                    if (oh_q[i]) st = arb_state_e'(ARB_SW'(i));
                end
            end

            // exactly one state bit is ever set (supports R1)
            onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(oh_q));
        end else begin : g_binary
            arb_state_e bin_q;

            // Holds the binary-coded state.
            always_ff @(posedge clk) begin
                if (!rst_n) bin_q <= ARB_RESET;
                else        bin_q <= nxt;
            end

            assign st = bin_q;
        end
    endgenerate

endmodule

// File: rtl/busarb_drive.sv
// Module: mode latch and output drive for the arbitration controller.
// Assumes st is the registered state; outputs are decoded from it.
module busarb_drive
    import busarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdog_rst,
    input  logic       three_wire,
    input  logic       bus_grant,
    input  logic       core_req,
    input  arb_state_e st,
    output logic       bus_req,
    output logic       bus_driven,
    output logic       addr_oe
);

    logic mode3_q;

    // Captures the wire mode only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wdog_rst || st == ARB_RESET) mode3_q <= three_wire;
    end

    // Produces the request and drive outputs.
    always_comb begin
        bus_req    = mode3_q && core_req && !bus_grant && (st != ARB_RESET);
        bus_driven = (st == ARB_EXPLICIT);
        addr_oe    = (st == ARB_EXPLICIT);
    end

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ARB_RESET && !wdog_rst) |=> $stable(mode3_q));

    // R8
    req_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (core_req && !bus_grant));

endmodule

// File: rtl/busarb_ctrl.sv
// Module: top of the bus arbitration controller.
// Assumes grant, request and cycle-end inputs are synchronous to clk.
module busarb_ctrl
    import busarb_pkg::*;
#(
    parameter bit ONEHOT_STATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdog_rst,
    input  logic three_wire,
    input  logic bus_grant,
    input  logic core_req,
    input  logic cyc_end,
    output logic bus_req,
    output logic bus_driven,
    output logic addr_oe
);

    arb_state_e st;
    arb_state_e nxt;

    busarb_next u_next (
        .st        (st),
        .rst_n     (rst_n),
        .wdog_rst  (wdog_rst),
        .bus_grant (bus_grant),
        .core_req  (core_req),
        .cyc_end   (cyc_end),
        .nxt       (nxt)
    );

    busarb_state_reg #(.ONEHOT_STATE(ONEHOT_STATE)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .st    (st)
    );

    busarb_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdog_rst   (wdog_rst),
        .three_wire (three_wire),
        .bus_grant  (bus_grant),
        .core_req   (core_req),
        .st         (st),
        .bus_req    (bus_req),
        .bus_driven (bus_driven),
        .addr_oe    (addr_oe)
    );

    // R2
    wdog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> (st == ARB_RESET && !bus_driven && !bus_req));

    // R3
    exit_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_RESET && !wdog_rst && bus_grant) |=> st == ARB_IMPLICIT);

    // R3
    exit_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_RESET && !wdog_rst && !bus_grant) |=> st == ARB_EXTERNAL);

    // R5
    take_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_IMPLICIT && bus_grant && core_req && !wdog_rst) |=> (bus_driven && addr_oe));

    // R6
    finish_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_EXPLICIT && !cyc_end && !wdog_rst) |=> (st == ARB_EXPLICIT && bus_driven));

    // R7
    regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_EXTERNAL && bus_grant && !wdog_rst) |=> st == ARB_IMPLICIT);

endmodule

// File: tb/test_busarb_ctrl.sv
module test_busarb_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdog_rst = 1'b0;
    logic three_wire = 1'b1;
    logic bus_grant = 1'b0;
    logic core_req = 1'b0;
    logic cyc_end = 1'b0;
    logic br_b, bd_b, oe_b;
    logic br_o, bd_o, oe_o;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    busarb_ctrl #(.ONEHOT_STATE(1'b0)) i_busarb_ctrl (
        .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst), .three_wire(three_wire),
        .bus_grant(bus_grant), .core_req(core_req), .cyc_end(cyc_end),
        .bus_req(br_b), .bus_driven(bd_b), .addr_oe(oe_b));

    busarb_ctrl #(.ONEHOT_STATE(1'b1)) i_busarb_ctrl_onehot (
        .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst), .three_wire(three_wire),
        .bus_grant(bus_grant), .core_req(core_req), .cyc_end(cyc_end),
        .bus_req(br_o), .bus_driven(bd_o), .addr_oe(oe_o));

    // Row: rst_n wdog mode grant req cyc_end | tag[3:0] | br bd oe
    localparam int NV = 21;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_1_0_0_0_0001_0_0_0, // R1 reset asserted
        13'b1_0_1_1_0_0_0011_0_0_0, // R3 leave reset with grant -> implicit
        13'b1_0_1_1_1_0_0101_0_1_1, // R5 take the bus
        13'b1_0_1_0_1_0_0110_1_1_1, // R6 grant lost, transfer continues
        13'b1_0_1_0_1_1_0110_1_0_0, // R6 transfer ends -> external
        13'b1_0_1_0_1_0_1000_1_0_0, // R8 request while external
        13'b1_0_1_1_1_0_0111_0_0_0, // R7 grant returns -> implicit
        13'b1_0_1_1_1_0_0101_0_1_1, // R5 explicit again
        13'b1_0_1_1_0_0_0110_0_1_1, // R6 request drops mid-transfer
        13'b1_0_1_1_0_1_0110_0_0_0, // R6 end with grant, no request -> implicit
        13'b1_0_1_0_0_0_0100_0_0_0, // R4 implicit loses grant -> external
        13'b1_0_1_0_1_0_1000_1_0_0, // R8 request raised
        13'b1_1_1_0_1_0_0010_0_0_0, // R2 watchdog reset
        13'b1_0_0_0_1_0_1001_0_0_0, // R9 two-wire latched, leave to external
        13'b1_0_1_0_1_0_1010_0_0_0, // R10 mode change outside reset ignored
        13'b1_0_1_1_1_0_0111_0_0_0, // R7 -> implicit
        13'b1_0_1_1_1_0_0101_0_1_1, // R5 -> explicit
        13'b1_0_1_0_1_0_1001_0_1_1, // R9 no request in two-wire
        13'b0_0_1_0_1_0_0001_0_0_0, // R1 reset from explicit
        13'b1_0_1_1_1_0_0011_0_0_0, // R3 -> implicit, three-wire latched
        13'b1_0_1_0_1_0_0100_1_0_0  // R4 implicit -> external, request shows
    };

    task automatic step(input logic rn, input logic wd, input logic md, input logic g,
                        input logic r, input logic ce, input int tag,
                        input logic ebr, input logic ebd, input logic eoe);
        @(negedge clk);
        rst_n = rn; wdog_rst = wd; three_wire = md;
        bus_grant = g; core_req = r; cyc_end = ce;
        @(posedge clk);
        #5;
        checks++;
        if ({br_b, bd_b, oe_b} !== {ebr, ebd, eoe} || {br_o, bd_o, oe_o} !== {ebr, ebd, eoe}) begin
            fails++;
            $display("FAIL R%0d: binary=%b onehot=%b expected=%b (br,bd,oe)",
                     tag, {br_b, bd_b, oe_b}, {br_o, bd_o, oe_o}, {ebr, ebd, eoe});
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset held over several edges
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            step(v[12], v[11], v[10], v[9], v[8], v[7], int'(v[6:3]), v[2], v[1], v[0]);
        end

        // R7 then R5: back to ownership
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5, 1'b0, 1'b1, 1'b1);
        // R6: transfer ends with grant and request still present -> stays explicit
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6, 1'b0, 1'b1, 1'b1);
        // R6: long transfer keeps the bus after the grant is lost
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6, 1'b1, 1'b1, 1'b1);
        // R2: watchdog aborts mid-transfer
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2, 1'b0, 1'b0, 1'b0);
        // R9: two-wire latched on the way out of reset
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7, 1'b0, 1'b0, 1'b0);
        // R9: implicit -> external with a request, still no bus request
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule